// File: doc/BRIEF.md
# Streaming Sobel/Prewitt Edge Detector

This block turns a single-plane pixel stream into a one-bit edge map. Pixels arrive in raster order with a valid/ready handshake. A frame-sync flag on the first pixel starts each frame, and the source may pause between pixels at will. Two line buffers and a 3x3 window feed two orthogonal gradient filters that run in parallel. The filters build every product from pass-through, a one-bit left shift and subtraction, so no multiplier is used.

The absolute values of the two gradients are added and the sum is compared with a threshold. Each pixel yields one output bit: 1 when the sum is strictly above the threshold, 0 otherwise. Frame width, frame height, kernel choice and threshold are runtime inputs. They are captured with the frame-sync pixel and held for the whole frame.

After the last pixel of a frame, the block lowers ready for W+1 cycles. During these cycles it produces the outputs of the final row, which need no further input.

Top module: `edge_detect`

## Requirements
- R1: A pixel is consumed only on a rising edge where valid_i and ready_o are both high; ready_o is high in reset and at all times except the end-of-frame completion window.
- R2: While no frame is in progress, pixels presented with sync_i low are consumed and discarded, and no output is produced for them.
- R3: After the W*H-th pixel of a frame is consumed, ready_o is low for exactly W+1 cycles and then returns high.
- R4: A "step" is an edge that consumes a frame pixel or falls in the completion window; steps are numbered from 0 at the sync pixel. The result for pixel p (raster index y*W+x) is presented with valid_o high for one cycle, starting at the first rising edge after step p+W+1, so every frame yields exactly W*H results in raster order.
- R5: sync_o is high together with valid_o on the result for pixel (0,0) of a frame, and low at every other time.
- R6: With mode_i = 0 (Sobel), the vertical gradient is the row below minus the row above, each row weighted 1,2,1 from left to right, and the horizontal gradient is the right column minus the left column, each column weighted 1,2,1 from top to bottom.
- R7: With mode_i = 1 (Prewitt), both gradients use the weights 1,1,1 instead of 1,2,1.
- R8: Window positions outside the frame take the value of the nearest pixel inside the frame, with row and column clamped independently.
- R9: edge_o is 1 exactly when |vertical| + |horizontal| is strictly greater than thresh_i, and 0 when the sum is equal to or below it.
- R10: width_i, height_i, mode_i and thresh_i are sampled on the sync pixel; changes to them during a frame do not affect that frame.
- R11: The gradient sum is carried without overflow up to 8*(2^DW-1), so high-contrast content is compared with the threshold correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | DW | Input pixel value |
| valid_i | input | 1 | Input pixel present |
| sync_i | input | 1 | Pixel is row 0, column 0 of a new frame |
| ready_o | output | 1 | Block can consume a pixel |
| width_i | input | $clog2(MAX_W+1) | Frame width W, 1..MAX_W |
| height_i | input | $clog2(MAX_H+1) | Frame height H, 1..MAX_H |
| mode_i | input | 1 | 0 = Sobel, 1 = Prewitt |
| thresh_i | input | DW+3 | Edge threshold |
| edge_o | output | 1 | Edge bit for the current result |
| valid_o | output | 1 | Result present |
| sync_o | output | 1 | Result is for pixel (0,0) |

## Verification
A step is decided by the inputs present at an edge. One register stage holds the window and the centre position, and a second holds the result, so each result is due one edge after the step that completes its window. Its pixel index is the step number minus W+1. ready_o reflects the state left by the previous edge.

The bench drives inputs on falling edges and predicts the step for the coming edge from the values it drove. It pushes the predicted result into a two-slot delay, so that it compares valid_o, edge_o and sync_o two falling edges later. ready_o is checked on every falling edge against the model's phase. After each frame, the number of results is compared with W*H.

// File: rtl/edge_pkg.sv
`timescale 1ns/1ps
package edge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } edge_state_e;
endpackage

// File: rtl/edge_linebuf.sv
`timescale 1ns/1ps
// Cascaded row delay lines, read-before-write at one shared column address.
module edge_linebuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int NROW  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] pix_i,
  output logic [DW-1:0] tap_o [NROW]
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] din;
    if (r == 0) begin : g_first
      assign din = pix_i;
    end else begin : g_next
      assign din = tap_o[r-1];
    end
    assign tap_o[r] = mem[addr_i];
    always_ff @(posedge clk_i) begin
      if (en_i) mem[addr_i] <= din;
    end
  end
endmodule

// File: rtl/edge_window.sv
`timescale 1ns/1ps
// 3x3 window from three column registers, with border replication.
module edge_window #(
  parameter int DW = 8,
  parameter int WW = 5,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] col_i [3],
  input  logic [WW-1:0] cen_col_i,
  input  logic [RW-1:0] cen_row_i,
  input  logic [WW-1:0] w_i,
  input  logic [RW-1:0] h_i,
  output logic [DW-1:0] win_o [3][3]
);
  // sr[0] newest (right), sr[1] centre, sr[2] left; element 0 top, 2 bottom
  logic [DW-1:0] sr  [3][3];
  logic [DW-1:0] sel [3][3];
  logic at_l, at_r, at_t, at_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 3; c++)
        for (int r = 0; r < 3; r++) sr[c][r] <= '0;
    end else if (en_i) begin
      sr[0] <= col_i;
      sr[1] <= sr[0];
      sr[2] <= sr[1];
    end
  end

  assign at_l = (cen_col_i == '0);
  assign at_r = (cen_col_i == w_i - WW'(1));
  assign at_t = (cen_row_i == '0);
  assign at_b = (cen_row_i == h_i - RW'(1));

  always_comb begin
    sel[0] = at_l ? sr[1] : sr[2];
    sel[1] = sr[1];
    sel[2] = at_r ? sr[1] : sr[0];
    for (int c = 0; c < 3; c++) begin
      win_o[0][c] = at_t ? sel[c][1] : sel[c][0];
      win_o[1][c] = sel[c][1];
      win_o[2][c] = at_b ? sel[c][1] : sel[c][2];
    end
  end
endmodule

// File: rtl/edge_grad.sv
`timescale 1ns/1ps
// One gradient: |(p0 + k*p1 + p2) - (n0 + k*n1 + n2)|, k = 2 or 1.
module edge_grad #(
  parameter int DW = 8,
  localparam int MW = DW + 2
) (
  input  logic [DW-1:0] pos_i [3],
  input  logic [DW-1:0] neg_i [3],
  input  logic          sobel_i,
  output logic [MW-1:0] mag_o
);
  logic [MW-1:0] ps, ns;

  always_comb begin
    ps = {2'b00, pos_i[0]} + {2'b00, pos_i[2]} +
         (sobel_i ? {1'b0, pos_i[1], 1'b0} : {2'b00, pos_i[1]});
    ns = {2'b00, neg_i[0]} + {2'b00, neg_i[2]} +
         (sobel_i ? {1'b0, neg_i[1], 1'b0} : {2'b00, neg_i[1]});
    mag_o = (ps >= ns) ? ps - ns : ns - ps;
  end
endmodule

// File: rtl/edge_detect.sv
`timescale 1ns/1ps
module edge_detect #(
  parameter int DW    = 8,
  parameter int MAX_W = 16,
  parameter int MAX_H = 16,
  localparam int WW   = $clog2(MAX_W + 1),
  localparam int HW   = $clog2(MAX_H + 1),
  localparam int RW   = $clog2(MAX_H + 2),
  localparam int AW   = $clog2(MAX_W),
  localparam int MW   = DW + 2,
  localparam int SW   = DW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pix_i,
  input  logic          valid_i,
  input  logic          sync_i,
  output logic          ready_o,
  input  logic [WW-1:0] width_i,
  input  logic [HW-1:0] height_i,
  input  logic          mode_i,
  input  logic [SW-1:0] thresh_i,
  output logic          edge_o,
  output logic          valid_o,
  output logic          sync_o
);
  import edge_pkg::*;

  edge_state_e   state_q;
  logic [WW-1:0] col_q, w_q, w_eff, ccol, cen_col_q;
  logic [RW-1:0] row_q, h_eff, crow, cen_row_q;
  logic [HW-1:0] h_q;
  logic          sobel_q, cen_v_q;
  logic [SW-1:0] thr_q, sum;
  logic          start, step, last_col, last_in, flush_end, cv;

  // ---------------- step control ----------------
  assign start     = (state_q == ST_IDLE) && valid_i && sync_i;
  assign step      = start || ((state_q == ST_RUN) && valid_i) || (state_q == ST_FLUSH);
  assign ready_o   = (state_q != ST_FLUSH);
  assign w_eff     = start ? width_i : w_q;
  assign h_eff     = RW'(start ? height_i : h_q);
  assign last_col  = (col_q == w_eff - WW'(1));
  assign last_in   = last_col && (row_q == h_eff - RW'(1));
  assign flush_end = (state_q == ST_FLUSH) && (col_q == '0) && (row_q == RW'(h_q) + RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      w_q     <= WW'(1);
      h_q     <= HW'(1);
      sobel_q <= 1'b1;
      thr_q   <= '0;
    end else begin
      if (start) begin
        w_q     <= width_i;
        h_q     <= height_i;
        sobel_q <= ~mode_i;
        thr_q   <= thresh_i;
      end
      if (step) begin
        if (flush_end) begin
          state_q <= ST_IDLE;
          col_q   <= '0;
          row_q   <= '0;
        end else begin
          if (last_col) begin
            col_q <= '0;
            row_q <= row_q + RW'(1);
          end else begin
            col_q <= col_q + WW'(1);
          end
          if (state_q != ST_FLUSH && last_in) state_q <= ST_FLUSH;
          else if (start)                     state_q <= ST_RUN;
        end
      end
    end
  end

  // centre of the window lags the incoming position by W+1 steps
  assign cv   = (row_q >= RW'(2)) || ((row_q == RW'(1)) && (col_q != '0));
  assign ccol = (col_q == '0) ? w_eff - WW'(1) : col_q - WW'(1);
  assign crow = (col_q == '0) ? row_q - RW'(2) : row_q - RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_v_q   <= 1'b0;
      cen_col_q <= '0;
      cen_row_q <= '0;
    end else begin
      cen_v_q <= step && cv;
      if (step) begin
        cen_col_q <= ccol;
        cen_row_q <= crow;
      end
    end
  end

  // ---------------- datapath ----------------
  logic [DW-1:0] tap [2];
  logic [DW-1:0] colv [3];
  logic [DW-1:0] win [3][3];

  edge_linebuf #(.DW(DW), .DEPTH(MAX_W), .NROW(2)) u_lbuf (
    .clk_i  (clk_i),
    .en_i   (step),
    .addr_i (col_q[AW-1:0]),
    .pix_i  (pix_i),
    .tap_o  (tap)
  );

  assign colv[0] = tap[1];
  assign colv[1] = tap[0];
  assign colv[2] = pix_i;

  edge_window #(.DW(DW), .WW(WW), .RW(RW)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (step),
    .col_i     (colv),
    .cen_col_i (cen_col_q),
    .cen_row_i (cen_row_q),
    .w_i       (w_q),
    .h_i       (RW'(h_q)),
    .win_o     (win)
  );

  logic [DW-1:0] gp [2][3];
  logic [DW-1:0] gn [2][3];
  logic [MW-1:0] mag [2];

  // d = 0: vertical (rows), d = 1: horizontal (columns)
  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar k = 0; k < 3; k++) begin : g_tap
      if (d == 0) begin : g_v
        assign gp[d][k] = win[2][k];
        assign gn[d][k] = win[0][k];
      end else begin : g_h
        assign gp[d][k] = win[k][2];
        assign gn[d][k] = win[k][0];
      end
    end
    edge_grad #(.DW(DW)) u_grad (
      .pos_i   (gp[d]),
      .neg_i   (gn[d]),
      .sobel_i (sobel_q),
      .mag_o   (mag[d])
    );
  end

  assign sum = {1'b0, mag[0]} + {1'b0, mag[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      edge_o  <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      valid_o <= cen_v_q;
      edge_o  <= cen_v_q && (sum > thr_q);
      sync_o  <= cen_v_q && (cen_col_q == '0) && (cen_row_q == '0);
    end
  end

  // ---------------- assertions ----------------
  AST_SYNC_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> valid_o); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum >= SW'(mag[0])) && (sum >= SW'(mag[1]))); // R11
  AST_SETTINGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(sobel_q) && $stable(thr_q) && $stable(w_q) && $stable(h_q))); // R10
  AST_FLUSH_AFTER_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(valid_i)); // R3
  AST_CENTER_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_v_q |-> ((cen_col_q < w_q) && (cen_row_q < RW'(h_q)))); // R4
endmodule

// File: tb/edge_detect_tb_top.sv
`timescale 1ns/1ps
module edge_detect_tb_top;
  localparam int DW = 8, MW = 16, MH = 16;
  localparam int WW = $clog2(MW + 1), HW = $clog2(MH + 1), SW = DW + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] pix_i = '0;
  logic valid_i = 1'b0, sync_i = 1'b0, mode_i = 1'b0;
  logic [WW-1:0] width_i = WW'(1);
  logic [HW-1:0] height_i = HW'(1);
  logic [SW-1:0] thresh_i = '0;
  logic ready_o, edge_o, valid_o, sync_o;

  always #10 clk = ~clk; // 50 MHz

  edge_detect #(.DW(DW), .MAX_W(MW), .MAX_H(MH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .valid_i(valid_i), .sync_i(sync_i),
    .ready_o(ready_o), .width_i(width_i), .height_i(height_i), .mode_i(mode_i),
    .thresh_i(thresh_i), .edge_o(edge_o), .valid_o(valid_o), .sync_o(sync_o));

  int n_chk = 0, n_fail = 0, ocnt = 0;
  bit done = 0;
  int phase = 0, s = 0, fw = 1, fh = 1, fmode = 0, fthr = 0;
  int img [MH][MW];
  bit due1 = 0, due2 = 0, exp1 = 0, exp2 = 0, syn1 = 0, syn2 = 0;
  string etag = "R9", vtag = "R4";

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int pixat(int y, int x);
    int yy = (y < 0) ? 0 : (y >= fh ? fh - 1 : y);
    int xx = (x < 0) ? 0 : (x >= fw ? fw - 1 : x);
    return img[yy][xx];
  endfunction

  function automatic bit ref_bit(int p);
    int y = p / fw, x = p % fw, k = fmode ? 1 : 2;
    int gv, gh;
    gv = (pixat(y+1,x-1) + k*pixat(y+1,x) + pixat(y+1,x+1))
       - (pixat(y-1,x-1) + k*pixat(y-1,x) + pixat(y-1,x+1));
    gh = (pixat(y-1,x+1) + k*pixat(y,x+1) + pixat(y+1,x+1))
       - (pixat(y-1,x-1) + k*pixat(y,x-1) + pixat(y+1,x-1));
    if (gv < 0) gv = -gv;
    if (gh < 0) gh = -gh;
    return (gv + gh) > fthr;
  endfunction

  task automatic tick(input bit v, input bit sy, input int pix, input int w, input int h,
                      input int mode, input int thr);
    bit st = 0;
    @(negedge clk);
    chk(phase == 2 ? "R3" : "R1", "ready_o", int'(ready_o), int'(phase != 2));
    chk(vtag, "valid_o", int'(valid_o), int'(due2));
    if (valid_o) ocnt++;
    if (due2) begin
      chk(etag, "edge_o", int'(edge_o), int'(exp2));
      chk("R5", "sync_o", int'(sync_o), int'(syn2));
    end else chk("R5", "sync_o idle", int'(sync_o), 0);
    due2 = due1; exp2 = exp1; syn2 = syn1; due1 = 0;
    valid_i = v; sync_i = sy; pix_i = DW'(pix); width_i = WW'(w); height_i = HW'(h);
    mode_i = mode[0]; thresh_i = SW'(thr);
    if (phase == 0) begin
      if (v && sy) begin
        fw = w; fh = h; fmode = mode; fthr = thr; phase = 1; s = 0; st = 1;
      end
    end else if (phase == 1) st = v;
    else st = 1;
    if (st) begin
      if (phase == 1) img[s / fw][s % fw] = pix % 256;
      if (s >= fw + 1) begin
        due1 = 1; exp1 = ref_bit(s - fw - 1); syn1 = (s - fw - 1 == 0);
      end
      s++;
      if (phase == 1 && s == fw * fh) phase = 2;
      else if (phase == 2 && s == fw * fh + fw + 1) phase = 0;
    end
  endtask

  function automatic int gen(int pat, int x, int y);
    case (pat)
      0: return (x * 37 + y * 11) % 256;
      1: return int'($urandom % 256);
      2: return 100;
      3: return (((x / 2) + (y / 2)) % 2) ? 255 : 0;
      4: return (x == 2 && y == 2) ? 200 : 0;
      default: return (x == 0 || y == 0) ? 250 : 10;
    endcase
  endfunction

  task automatic run_frame(input int w, input int h, input int mode, input int thr, input int pat,
                           input bit burst, input bit noise, input bit junk, input string tag);
    etag = tag; ocnt = 0;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        bit first = (x == 0 && y == 0);
        int pv = gen(pat, x, y);
        if (burst && !first) repeat (int'($urandom % 3)) tick(0, 0, 0, 1, 1, mode ^ 1, thr ^ 'h2aa);
        if (noise && !first) tick(1, 0, pv, 1, 1, mode ^ 1, thr ^ 'h2aa);
        else tick(1, first, pv, w, h, mode, thr);
      end
    while (phase != 0) tick(junk, 0, 77, w, h, mode, thr);
    repeat (2) tick(0, 0, 0, w, h, mode, thr);
    chk("R4", "result count", ocnt, w * h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready_o in reset", int'(ready_o), 1);
    chk("R4", "valid_o in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    // R2: stray pixels without frame sync are dropped
    vtag = "R2"; ocnt = 0;
    repeat (3) tick(1, 0, 55, 4, 4, 0, 0);
    repeat (4) tick(0, 0, 0, 4, 4, 0, 0);
    chk("R2", "results from stray pixels", ocnt, 0);
    vtag = "R4";
    run_frame(8, 6, 0, 60, 0, 0, 0, 0, "R6");
    run_frame(8, 6, 1, 100, 1, 1, 1, 1, "R10");   // R7 Prewitt, bursty, settings noise
    run_frame(7, 5, 1, 40, 0, 0, 0, 0, "R7");
    run_frame(1, 1, 0, 0, 2, 0, 0, 0, "R9");
    run_frame(MW, 4, 0, 1019, 3, 0, 0, 0, "R11");
    run_frame(6, 5, 0, 40, 5, 1, 0, 0, "R8");
    run_frame(5, 5, 0, 400, 4, 0, 0, 0, "R9");
    run_frame(5, 5, 0, 399, 4, 0, 0, 0, "R9");
    run_frame(5, 5, 1, 199, 4, 0, 0, 1, "R7");
    run_frame(3, 1, 0, 80, 1, 1, 0, 0, "R8");
    run_frame(4, MH, 1, 90, 1, 0, 0, 0, "R6");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule